// File: doc/BRIEF.md
# DMA Request/Acknowledge Write Port

This block is the device-side end of a single-word DMA write channel. It tells an external DMA engine that it can take data by driving an active-low request line. It takes exactly one 32-bit word for each active-low acknowledge strobe. The stored word goes into a 16-entry first-in first-out buffer, which downstream logic drains through a read port that shows the oldest word. The acknowledge and write-enable inputs arrive from another clock domain. They are resynchronized, and the data bus is delayed by the same number of stages, so a word is always captured together with the acknowledge edge that goes with it. All handshake timing is measured in core clock cycles.

A 4-bit length setting selects how the request is signalled. A value of 1 to 15 produces a request pulse of that many clocks. After the acknowledge is seen, the next pulse starts right away if the buffer still has room for the word in flight. A value of zero produces a request level. It stays asserted until the acknowledge is seen, and it is raised again once the transferred word has been stored. Strobes that are too short, strobes without write-enable, and strobes that arrive while the buffer is full never write. The last two also set a sticky error flag. While the buffer is full, no request is issued.

Top module: `dmareq_wr_port`

## Requirements
- R1: While `rst_n` is low on a clock edge, the block drives `req_n` high, `fifo_count` 0, `fifo_full` 0 and `xfer_err` 0.
- R2: With `cfg_req_len` = 0, `req_n` goes low on the first edge after reset and stays low until `ack_n` falls. It goes high on the third rising edge after `ack_n` is driven low. It goes low again on the fourth rising edge after `ack_n` returns high, provided there is space.
- R3: With `cfg_req_len` = L (1 to 15) and no acknowledge, `req_n` is low for exactly L consecutive clock cycles and then stays high.
- R4: In pulse mode, when `ack_n` falls and the buffer will still have a free entry after the word in flight, a new pulse starts on the third rising edge after the fall.
- R5: A valid strobe writes one word: `ack_n` low for at least 2 sampled cycles, preceded by at least 2 high cycles, with `wen_n` low on the edges that sample both the fall and the rise. The word is the `hdata` value driven together with the rising `ack_n`. `fifo_count` increments on the third rising edge after `ack_n` returns high.
- R6: A strobe whose low time or preceding high time is shorter than 2 cycles writes nothing and leaves `xfer_err` unchanged.
- R7: A strobe of valid width with `wen_n` high at either sampled edge writes nothing and sets `xfer_err`, which stays set until reset.
- R8: `fifo_full` is 1 exactly when `fifo_count` is 16. While it is set, `req_n` stays high, and a valid strobe writes nothing and sets `xfer_err`.
- R9: `rd_data` shows the oldest stored word. A high `rd_en` on a rising edge with data present removes it in write order, and `fifo_count` drops on that edge. In level mode, a request is raised on the next edge once space exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_req_len | input | 4 | Request pulse length in clocks; 0 selects level request |
| ack_n | input | 1 | Transfer acknowledge from DMA engine, active low, asynchronous |
| wen_n | input | 1 | Write enable qualifying the acknowledge, active low, asynchronous |
| hdata | input | 32 | Write data bus |
| rd_en | input | 1 | Pop the oldest buffered word |
| req_n | output | 1 | DMA request, active low |
| fifo_full | output | 1 | Buffer holds 16 words |
| xfer_err | output | 1 | Sticky flag for a strobe rejected by write-enable or a full buffer |
| rd_data | output | 32 | Oldest buffered word |
| fifo_count | output | 5 | Number of buffered words |

## Verification
Every result reached through the input synchronizer is due a fixed number of rising edges after the stimulus. A request drop after an acknowledge fall is due on the third edge. A buffer write after the acknowledge rise is also due on the third edge. A level re-request after a write is due on the fourth edge. A pop shows on the first edge after `rd_en`. The bench changes inputs and samples outputs only on falling clock edges, and it counts those falling edges from the one where the stimulus was applied. Each check therefore lands on the half cycle where the value first becomes valid, and the neighbouring sample confirms that the change did not come early.

// File: rtl/dmawp_pkg.sv
// Package: shared types for the DMA request/acknowledge write port.
// Assumes: nothing beyond IEEE 1800-2017.
package dmawp_pkg;
    // Request generator states; PULSE and LEVEL drive the request active.
    typedef enum logic [1:0] {
        RQ_IDLE  = 2'd0,
        RQ_PULSE = 2'd1,
        RQ_LEVEL = 2'd2,
        RQ_ARMED = 2'd3
    } rq_state_t;
endpackage

// File: rtl/dmawp_delay.sv
// Module: dmawp_delay
// A chain of STAGES registers. It serves as a synchronizer for asynchronous
// control inputs, and as the matching delay for the data bus so that data
// stays aligned with the synchronized acknowledge.
// Assumes: STAGES >= 1; synchronous active-low reset loads RST in every stage.
module dmawp_delay #(
    parameter int             W      = 1,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the input through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST}};
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dmawp_ack_qual.sv
// Module: dmawp_ack_qual
// Finds edges on the synchronized acknowledge and checks the minimum low
// and high times. A transfer is qualified by write-enable at both edges and
// by free buffer space. The write strobe is raised on the qualified rising
// edge. Rejected strobes of valid width set a sticky error.
// Assumes: inputs are already synchronized to clk; data is delay-matched.
module dmawp_ack_qual #(
    parameter int DW    = 32,
    parameter int MIN_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_ack_n,
    input  logic          s_wen_n,
    input  logic [DW-1:0] s_data,
    input  logic          fifo_full,
    output logic          ack_fall,
    output logic          ack_idle,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          xfer_err
);
    localparam int            CW  = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] SAT = CW'(MIN_W);

    logic          prev_ack_n;
    logic          gap_ok;
    logic          wen_at_fall;
    logic          err_q;
    logic [CW-1:0] low_cnt;
    logic [CW-1:0] high_cnt;
    logic          raw_fall;
    logic          raw_rise;
    logic          width_ok;
    logic          xfer_ok;

    assign raw_fall = prev_ack_n & ~s_ack_n;
    assign raw_rise = ~prev_ack_n & s_ack_n;
    assign width_ok = raw_rise & gap_ok & (low_cnt == SAT);
    assign xfer_ok  = wen_at_fall & ~s_wen_n & ~fifo_full;
    assign ack_fall = raw_fall & (high_cnt == SAT);
    assign ack_idle = prev_ack_n & s_ack_n;
    assign wr_en    = width_ok & xfer_ok;
    assign wr_data  = s_data;
    assign xfer_err = err_q;

    // Remember the previous acknowledge level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_ack_n <= 1'b1;
        else        prev_ack_n <= s_ack_n;
    end

    // Count low and high run lengths, saturating at the minimum width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= SAT;
        end else if (raw_fall) begin
            low_cnt  <= CW'(1);
        end else if (raw_rise) begin
            high_cnt <= CW'(1);
        end else if (!s_ack_n && low_cnt != SAT) begin
            low_cnt  <= low_cnt + CW'(1);
        end else if (s_ack_n && high_cnt != SAT) begin
            high_cnt <= high_cnt + CW'(1);
        end
    end

    // Latch gap validity and write-enable when the acknowledge falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_ok      <= 1'b0;
            wen_at_fall <= 1'b0;
        end else if (raw_fall) begin
            gap_ok      <= (high_cnt == SAT);
            wen_at_fall <= ~s_wen_n;
        end
    end

    // Set the sticky error when a well-formed strobe cannot be accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                    err_q <= 1'b0;
        else if (width_ok && !xfer_ok) err_q <= 1'b1;
    end

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> xfer_err);

    p_one_write_per_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    p_no_write_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !wr_en);
endmodule

// File: rtl/dmawp_req_gen.sv
// Module: dmawp_req_gen
// Drives the active-low DMA request. A non-zero length gives a pulse of that
// many clocks and re-arms on each acknowledge. Zero gives a level that is
// released by the acknowledge and raised again once the line is idle.
// Assumes: ack_fall/ack_idle come from the synchronized acknowledge;
// room_now means one free entry and room_next means two.
module dmawp_req_gen #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cfg_len,
    input  logic          ack_fall,
    input  logic          ack_idle,
    input  logic          room_now,
    input  logic          room_next,
    output logic          req_n
);
    import dmawp_pkg::*;

    rq_state_t     state;
    logic [LW-1:0] timer;
    logic          pulse_mode;

    assign pulse_mode = (cfg_len != '0);

    // Request state machine with pulse timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RQ_IDLE;
            timer <= '0;
        end else begin
            unique case (state)
                RQ_IDLE: begin
                    if (ack_idle && room_now) begin
                        if (pulse_mode) begin
                            state <= RQ_PULSE;
                            timer <= cfg_len;
                        end else begin
                            state <= RQ_LEVEL;
                        end
                    end
                end
                RQ_PULSE, RQ_ARMED: begin
                    if (ack_fall) begin
                        if (pulse_mode && room_next) begin
                            state <= RQ_PULSE;
                            timer <= cfg_len;
                        end else begin
                            state <= RQ_IDLE;
                        end
                    end else if (state == RQ_PULSE) begin
                        if (timer == LW'(1)) state <= RQ_ARMED;
                        else                 timer <= timer - LW'(1);
                    end
                end
                RQ_LEVEL: begin
                    if (ack_fall) state <= RQ_IDLE;
                end
                default: state <= RQ_IDLE;
            endcase
        end
    end

    assign req_n = !(state == RQ_PULSE || state == RQ_LEVEL);

    p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RQ_LEVEL && !ack_fall) |=> !req_n);

    p_pulse_timer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RQ_PULSE) |-> (timer != '0));

    p_no_req_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !room_now |-> req_n);
endmodule

// File: rtl/dmawp_fifo.sv
// Module: dmawp_fifo
// Synchronous first-in first-out buffer with a show-ahead read port and an
// occupancy count. Writes when full and reads when empty are dropped.
// Assumes: DEPTH is a power of two.
module dmawp_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [DW-1:0]           wr_data,
    input  logic                    rd_en,
    output logic [DW-1:0]           rd_data,
    output logic [$clog2(DEPTH):0]  count,
    output logic                    full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push;
    logic          pop;

    assign full    = (count == CW'(DEPTH));
    assign push    = wr_en && !full;
    assign pop     = rd_en && (count != '0);
    assign rd_data = mem[rd_ptr];

    // Store incoming words.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (pop)  rd_ptr <= rd_ptr + AW'(1);
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (count <= CW'(DEPTH)));

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + CW'(1)) ||
        (count + CW'(1) == $past(count)));
endmodule

// File: rtl/dmareq_wr_port.sv
// Module: dmareq_wr_port
// Top level of the DMA request/acknowledge write port. It synchronizes the
// handshake inputs, delays data to match, qualifies strobes, generates the
// request and buffers the accepted words.
// Assumes: ack_n and wen_n are asynchronous; hdata is stable around the
// acknowledge rising edge for at least SYNC core clocks.
module dmareq_wr_port #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int LW    = 4,
    parameter int MIN_W = 2,
    parameter int SYNC  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LW-1:0]          cfg_req_len,
    input  logic                   ack_n,
    input  logic                   wen_n,
    input  logic [DW-1:0]          hdata,
    input  logic                   rd_en,
    output logic                   req_n,
    output logic                   fifo_full,
    output logic                   xfer_err,
    output logic [DW-1:0]          rd_data,
    output logic [$clog2(DEPTH):0] fifo_count
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [1:0]    s_ctl;
    logic [DW-1:0] s_data;
    logic          ack_fall;
    logic          ack_idle;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic          room_next;

    dmawp_delay #(.W(2), .STAGES(SYNC), .RST(2'b11)) u_ctl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ack_n, wen_n}),
        .q    (s_ctl)
    );

    dmawp_delay #(.W(DW), .STAGES(SYNC), .RST('0)) u_data_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (hdata),
        .q    (s_data)
    );

    dmawp_ack_qual #(.DW(DW), .MIN_W(MIN_W)) u_ack_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_ack_n  (s_ctl[1]),
        .s_wen_n  (s_ctl[0]),
        .s_data   (s_data),
        .fifo_full(fifo_full),
        .ack_fall (ack_fall),
        .ack_idle (ack_idle),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .xfer_err (xfer_err)
    );

    assign room_next = (fifo_count < CW'(DEPTH - 1));

    dmawp_req_gen #(.LW(LW)) u_req_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_len  (cfg_req_len),
        .ack_fall (ack_fall),
        .ack_idle (ack_idle),
        .room_now (!fifo_full),
        .room_next(room_next),
        .req_n    (req_n)
    );

    dmawp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .rd_data(rd_data),
        .count  (fifo_count),
        .full   (fifo_full)
    );
endmodule

// File: tb/test_dmareq_wr_port.sv
module test_dmareq_wr_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_req_len = 4'd0;
    logic        ack_n = 1'b1;
    logic        wen_n = 1'b1;
    logic [31:0] hdata = '0;
    logic        rd_en = 1'b0;
    logic        req_n;
    logic        fifo_full;
    logic        xfer_err;
    logic [31:0] rd_data;
    logic [4:0]  fifo_count;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmareq_wr_port i_dmareq_wr_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_req_len(cfg_req_len),
        .ack_n      (ack_n),
        .wen_n      (wen_n),
        .hdata      (hdata),
        .rd_en      (rd_en),
        .req_n      (req_n),
        .fifo_full  (fifo_full),
        .xfer_err   (xfer_err),
        .rd_data    (rd_data),
        .fifo_count (fifo_count)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reset with a chosen request length; checks R1 during reset.
    task automatic do_reset(input logic [3:0] len);
        rst_n = 1'b0; cfg_req_len = len; ack_n = 1'b1; wen_n = 1'b1; rd_en = 1'b0;
        repeat (3) tick();
        chk("R1 req_n in reset", {31'd0, req_n}, 32'd1);
        chk("R1 count in reset", {27'd0, fifo_count}, 32'd0);
        chk("R1 full in reset", {31'd0, fifo_full}, 32'd0);
        chk("R1 err in reset", {31'd0, xfer_err}, 32'd0);
        rst_n = 1'b1;
    endtask

    // One acknowledge strobe, then 4 idle-high samples.
    task automatic do_ack(input logic [31:0] data, input int low, input bit wen_ok);
        ack_n = 1'b0; wen_n = !wen_ok; hdata = data;
        repeat (low) tick();
        ack_n = 1'b1;
        tick();
        wen_n = 1'b1;
        repeat (3) tick();
    endtask

    task automatic t_level();
        do_reset(4'd0);
        repeat (5) tick();
        chk("R2 level req held", {31'd0, req_n}, 32'd0);
        ack_n = 1'b0; wen_n = 1'b0; hdata = 32'hA5A5_0001;
        tick(); tick();
        chk("R2 req before third edge", {31'd0, req_n}, 32'd0);
        tick();
        chk("R2 req released", {31'd0, req_n}, 32'd1);
        ack_n = 1'b1;
        tick(); wen_n = 1'b1;
        tick();
        chk("R5 count before third edge", {27'd0, fifo_count}, 32'd0);
        tick();
        chk("R5 count after write", {27'd0, fifo_count}, 32'd1);
        chk("R2 req not yet raised", {31'd0, req_n}, 32'd1);
        tick();
        chk("R2 level re-request", {31'd0, req_n}, 32'd0);
        chk("R5 captured word", rd_data, 32'hA5A5_0001);
    endtask

    task automatic t_pulse();
        foreach (lens_q[k]) begin
            int lows = 0;
            do_reset(lens_q[k]);
            for (int i = 0; i < 20; i++) begin
                tick();
                if (!req_n) lows++;
            end
            chk($sformatf("R3 pulse width len %0d", lens_q[k]), lows, lens_q[k]);
        end
    endtask
    logic [3:0] lens_q [3] = '{4'd1, 4'd5, 4'd15};

    task automatic t_rearm();
        do_reset(4'd3);
        repeat (8) tick();
        chk("R4 armed idle", {31'd0, req_n}, 32'd1);
        ack_n = 1'b0; wen_n = 1'b0; hdata = 32'h0000_BEEF;
        tick(); tick();
        chk("R4 no early pulse", {31'd0, req_n}, 32'd1);
        tick();
        chk("R4 new pulse", {31'd0, req_n}, 32'd0);
        ack_n = 1'b1;
        tick(); wen_n = 1'b1;
        repeat (3) tick();
        chk("R4 word stored", {27'd0, fifo_count}, 32'd1);
    endtask

    task automatic t_order();
        do_reset(4'd0);
        for (int i = 0; i < 3; i++) do_ack(32'h100 + i, 2, 1'b1);
        chk("R5 three words", {27'd0, fifo_count}, 32'd3);
        for (int i = 0; i < 3; i++) begin
            chk("R9 read order", rd_data, 32'h100 + i);
            rd_en = 1'b1; tick(); rd_en = 1'b0;
        end
        chk("R9 drained", {27'd0, fifo_count}, 32'd0);
    endtask

    task automatic t_short();
        do_reset(4'd0);
        tick();
        do_ack(32'h11, 1, 1'b1);
        chk("R6 short low ignored", {27'd0, fifo_count}, 32'd0);
        chk("R6 no error", {31'd0, xfer_err}, 32'd0);
        wen_n = 1'b0; hdata = 32'h22;
        ack_n = 1'b0; repeat (3) tick();
        ack_n = 1'b1; tick();
        hdata = 32'h33;
        ack_n = 1'b0; repeat (3) tick();
        ack_n = 1'b1; tick();
        wen_n = 1'b1; repeat (4) tick();
        chk("R6 short gap ignored", {27'd0, fifo_count}, 32'd1);
        chk("R6 first word kept", rd_data, 32'h22);
        chk("R6 gap no error", {31'd0, xfer_err}, 32'd0);
    endtask

    task automatic t_wen();
        do_reset(4'd0);
        do_ack(32'h44, 3, 1'b0);
        chk("R7 no write", {27'd0, fifo_count}, 32'd0);
        chk("R7 error set", {31'd0, xfer_err}, 32'd1);
        do_ack(32'h55, 3, 1'b1);
        chk("R7 error sticky", {31'd0, xfer_err}, 32'd1);
        chk("R7 later write ok", {27'd0, fifo_count}, 32'd1);
    endtask

    task automatic t_full();
        int hi = 0;
        do_reset(4'd0);
        for (int i = 0; i < 16; i++) do_ack(32'h200 + i, 2, 1'b1);
        chk("R8 count 16", {27'd0, fifo_count}, 32'd16);
        chk("R8 full set", {31'd0, fifo_full}, 32'd1);
        for (int i = 0; i < 10; i++) begin
            tick();
            if (req_n) hi++;
        end
        chk("R8 no request while full", hi, 32'd10);
        do_ack(32'hDEAD, 3, 1'b1);
        chk("R8 dropped when full", {27'd0, fifo_count}, 32'd16);
        chk("R8 error when full", {31'd0, xfer_err}, 32'd1);
        chk("R9 head word", rd_data, 32'h200);
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk("R9 count after pop", {27'd0, fifo_count}, 32'd15);
        chk("R8 full cleared", {31'd0, fifo_full}, 32'd0);
        chk("R9 next word", rd_data, 32'h201);
        tick();
        chk("R9 request resumes", {31'd0, req_n}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog (all requirements): actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick();
        t_level();
        t_pulse();
        t_rearm();
        t_order();
        t_short();
        t_wen();
        t_full();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule